// File: doc/BRIEF.md
# Physical Memory Access Guard

This block decides, in one combinational pass, whether a physical memory access may go ahead. It looks at a small table of protection entries. Each entry supplies a decoded region, given as an inclusive base and an exclusive limit, and a configuration byte. The byte holds three permission bits, a two-bit address-mode field and a lock bit. The block takes the access address, the access size in bytes, the access kind and the current privilege level. It returns an allow flag and, when the access is refused, the exception code that belongs to the access kind.

The block assumes the regions have already been decoded from the address registers, and it never writes the table. A parameter inserts one register stage at the output, so the verdict can be timed against a pipeline stage. With that parameter cleared, the verdict follows the inputs within the same cycle.

Entries are scanned from index 0 upward, and the first active entry that fully contains the access settles the verdict. Machine mode passes through any entry that is not locked. When no entry is active, no checking takes place at all.

Top module: `mem_guard_check`

## Requirements
- R1: When several active entries contain the access, only the one with the lowest index decides the verdict.
- R2: An entry contains an access only if both the first byte (address) and the last byte (address + size - 1) satisfy base <= byte < limit. An access that crosses either edge of a region gets no verdict from that entry.
- R3: At privilege level 3 (machine), an access contained by an entry whose lock bit (bit 7) is clear is allowed.
- R4: The configuration byte is laid out as follows: bit 0 grants read, bit 1 grants write, bit 2 grants execute, bits 4:3 hold the mode (0 = off, nonzero = active), bits 6:5 are ignored and bit 7 is the lock. Outside the case of R3, the deciding entry allows the access only if the permission bit for the access kind is set.
- R5: When checking is in effect and no active entry contains the access, machine level is allowed and levels 0 to 2 are refused.
- R6: Checking is in effect only when at least one entry is active, and either the level is not machine or some entry (active or not) has its lock bit set. Otherwise every access is allowed.
- R7: The access kind is encoded as 0 = read, 1 = write, 2 = execute, and 3 is treated as execute. A refused access reports code 5 for read, 7 for write and 1 for execute. An allowed access reports code 0.
- R8: An access size of 0 is treated as a size of 1.
- R9: With REG_OUT = 1 the verdict appears one clock after the inputs. While reset is high, the outputs hold allowed with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage and the checks |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | ADDR_W | Physical address of the first byte accessed |
| acc_size | input | SIZE_W | Access size in bytes (0 treated as 1) |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute, 3 as execute |
| priv_lvl | input | 2 | Current privilege level, 3 = machine |
| rgn_base | input | N_ENT*ADDR_W | Inclusive region base per entry, entry i at bits i*ADDR_W |
| rgn_limit | input | N_ENT*ADDR_W | Exclusive region limit per entry |
| ent_cfg | input | N_ENT*8 | Configuration byte per entry, entry i at bits i*8 |
| acc_ok | output | 1 | 1 = access allowed |
| exc_code | output | 4 | Fault code when refused, 0 when allowed |

## Verification
The interesting collisions happen when priority selection and the machine-mode pass-through act in the same cycle. One example is a locked low entry that overlaps an unlocked, more permissive high entry. Another is an access that crosses the edge of a low entry while lying fully inside a higher one. The sweeps set up overlapping tables of this kind and walk misaligned addresses of every size across each region edge, under every level and every access kind. Each verdict and code is compared with a bench model that applies the requirements directly, and each check is tagged with the rule that settled it.

// File: rtl/mguard_pkg.sv
package mguard_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_RANGE = 2'd1,
        AM_WORD  = 2'd2,
        AM_POW2  = 2'd3
    } amode_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        amode_e     amode;
        logic       x;
        logic       w;
        logic       r;
    } ent_cfg_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_kind_e;

    localparam logic [1:0] PRIV_MACH = 2'd3;
    localparam int         CODE_W    = 4;

    localparam logic [CODE_W-1:0] CODE_NONE  = 4'd0;
    localparam logic [CODE_W-1:0] CODE_FETCH = 4'd1;
    localparam logic [CODE_W-1:0] CODE_LOAD  = 4'd5;
    localparam logic [CODE_W-1:0] CODE_STORE = 4'd7;

    typedef struct packed {
        logic              ok;
        logic [CODE_W-1:0] code;
    } verdict_t;

    function automatic logic [CODE_W-1:0] fault_code(acc_kind_e k);
        case (k)
            ACC_LOAD:  return CODE_LOAD;
            ACC_STORE: return CODE_STORE;
            default:   return CODE_FETCH;
        endcase
    endfunction

    function automatic logic perm_for(logic [2:0] perm, acc_kind_e k);
        case (k)
            ACC_LOAD:  return perm[0];
            ACC_STORE: return perm[1];
            default:   return perm[2];
        endcase
    endfunction

endpackage

// File: rtl/mguard_entry_match.sv
module mguard_entry_match
    import mguard_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W:0]   last_addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  amode_e            amode,
    output logic              active,
    output logic              hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] base_x;
    logic [EXT_W-1:0] limit_x;
    logic [EXT_W-1:0] addr_x;
    logic             lo_ok;
    logic             hi_ok;

    always_comb begin
        base_x  = {1'b0, base};
        limit_x = {1'b0, limit};
        addr_x  = {1'b0, addr};
        active  = (amode != AM_OFF);
        lo_ok   = (addr_x >= base_x) && (addr_x < limit_x);
        hi_ok   = (last_addr >= base_x) && (last_addr < limit_x);
        hit     = active && lo_ok && hi_ok;
    end

endmodule

// File: rtl/mguard_pick.sv
module mguard_pick
    import mguard_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_ENT-1:0]   hit_v,
    input  logic [N_ENT-1:0]   lock_v,
    input  logic [3*N_ENT-1:0] perm_flat,
    output logic [N_ENT-1:0]   grant,
    output logic               found,
    output logic               sel_lock,
    output logic [2:0]         sel_perm
);
    localparam int PERM_W = 3;

    always_comb begin
        grant    = '0;
        found    = 1'b0;
        sel_lock = 1'b0;
        sel_perm = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!found && hit_v[i]) begin
                found    = 1'b1;
                grant[i] = 1'b1;
                sel_lock = lock_v[i];
                sel_perm = perm_flat[PERM_W*i +: PERM_W];
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R1
    AST_GRANT_IS_HIT: assert property (@(posedge clk) disable iff (rst)
        (grant & ~hit_v) == '0); // R1
    AST_NO_LOWER_HIT: assert property (@(posedge clk) disable iff (rst)
        ((grant - N_ENT'(1)) & hit_v) == '0); // R1

endmodule

// File: rtl/mguard_decide.sv
module mguard_decide
    import mguard_pkg::*;
#(
    parameter int N_ENT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_ENT-1:0] act_v,
    input  logic [N_ENT-1:0] lock_v,
    input  logic             found,
    input  logic             sel_lock,
    input  logic [2:0]       sel_perm,
    input  logic [1:0]       priv,
    input  acc_kind_e        kind,
    output verdict_t         verdict
);
    logic is_mach;
    logic chk_en;
    logic ok;

    always_comb begin
        is_mach = (priv == PRIV_MACH);
        chk_en  = (|act_v) && (!is_mach || (|lock_v));
        ok      = 1'b1;
        if (chk_en) begin
            if (found) begin
                ok = (is_mach && !sel_lock) ? 1'b1 : perm_for(sel_perm, kind);
            end else begin
                ok = is_mach;
            end
        end
        verdict.ok   = ok;
        verdict.code = ok ? CODE_NONE : fault_code(kind);
    end

    AST_IDLE_ALLOWS: assert property (@(posedge clk) disable iff (rst)
        !(|act_v) |-> verdict.ok); // R6
    AST_MACH_UNLOCKED_FREE: assert property (@(posedge clk) disable iff (rst)
        (is_mach && !(|lock_v)) |-> verdict.ok); // R6
    AST_LOW_NOMATCH_REFUSED: assert property (@(posedge clk) disable iff (rst)
        ((|act_v) && !is_mach && !found) |-> !verdict.ok); // R5
    AST_MACH_NOMATCH_OK: assert property (@(posedge clk) disable iff (rst)
        (is_mach && !found) |-> verdict.ok); // R5

endmodule

// File: rtl/mem_guard_check.sv
module mem_guard_check
    import mguard_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SIZE_W  = 4,
    parameter int N_ENT   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [SIZE_W-1:0]       acc_size,
    input  logic [1:0]              acc_kind,
    input  logic [1:0]              priv_lvl,
    input  logic [N_ENT*ADDR_W-1:0] rgn_base,
    input  logic [N_ENT*ADDR_W-1:0] rgn_limit,
    input  logic [N_ENT*8-1:0]      ent_cfg,
    output logic                    acc_ok,
    output logic [CODE_W-1:0]       exc_code
);
    localparam int EXT_W  = ADDR_W + 1;
    localparam int CFG_W  = 8;
    localparam int PERM_W = 3;

    logic [SIZE_W-1:0]       eff_size;
    logic [EXT_W-1:0]        last_addr;
    ent_cfg_t                cfg_arr [N_ENT];
    logic [N_ENT-1:0]        hit_v;
    logic [N_ENT-1:0]        act_v;
    logic [N_ENT-1:0]        lock_v;
    logic [PERM_W*N_ENT-1:0] perm_flat;
    logic [2*N_ENT-1:0]      rsvd_flat;
    logic                    unused_rsvd;
    logic [N_ENT-1:0]        grant;
    logic                    found;
    logic                    sel_lock;
    logic [2:0]              sel_perm;
    verdict_t                comb_v;

    always_comb begin
        eff_size  = (acc_size == '0) ? SIZE_W'(1) : acc_size;
        last_addr = {1'b0, acc_addr} + EXT_W'(eff_size) - EXT_W'(1);
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign cfg_arr[g]                    = ent_cfg_t'(ent_cfg[g*CFG_W +: CFG_W]);
        assign lock_v[g]                     = cfg_arr[g].lock;
        assign perm_flat[g*PERM_W +: PERM_W] = {cfg_arr[g].x, cfg_arr[g].w, cfg_arr[g].r};
        assign rsvd_flat[2*g +: 2]           = cfg_arr[g].rsvd;

        mguard_entry_match #(
            .ADDR_W (ADDR_W)
        ) i_match (
            .addr      (acc_addr),
            .last_addr (last_addr),
            .base      (rgn_base[g*ADDR_W +: ADDR_W]),
            .limit     (rgn_limit[g*ADDR_W +: ADDR_W]),
            .amode     (cfg_arr[g].amode),
            .active    (act_v[g]),
            .hit       (hit_v[g])
        );
    end

    assign unused_rsvd = ^rsvd_flat;

    mguard_pick #(
        .N_ENT (N_ENT)
    ) i_pick (
        .clk       (clk),
        .rst       (rst),
        .hit_v     (hit_v),
        .lock_v    (lock_v),
        .perm_flat (perm_flat),
        .grant     (grant),
        .found     (found),
        .sel_lock  (sel_lock),
        .sel_perm  (sel_perm)
    );

    mguard_decide #(
        .N_ENT (N_ENT)
    ) i_decide (
        .clk      (clk),
        .rst      (rst),
        .act_v    (act_v),
        .lock_v   (lock_v),
        .found    (found),
        .sel_lock (sel_lock),
        .sel_perm (sel_perm),
        .priv     (priv_lvl),
        .kind     (acc_kind_e'(acc_kind)),
        .verdict  (comb_v)
    );

    if (REG_OUT) begin : g_reg
        verdict_t out_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                out_q <= '{ok: 1'b1, code: CODE_NONE};
            end else begin
                out_q <= comb_v;
            end
        end
        assign acc_ok   = out_q.ok;
        assign exc_code = out_q.code;
    end else begin : g_comb
        assign acc_ok   = comb_v.ok;
        assign exc_code = comb_v.code;
    end

    AST_OK_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        acc_ok |-> (exc_code == CODE_NONE)); // R7
    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        !acc_ok |-> (exc_code == CODE_LOAD || exc_code == CODE_STORE
                     || exc_code == CODE_FETCH)); // R7
    AST_LAST_NOT_BELOW: assert property (@(posedge clk) disable iff (rst)
        last_addr >= {1'b0, acc_addr}); // R8

endmodule

// File: tb/test_mem_guard_check.sv
`timescale 1ns/100ps
module test_mem_guard_check;
    localparam int AW = 16;
    localparam int SW = 4;
    localparam int NE = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AW-1:0]  acc_addr = '0;
    logic [SW-1:0]  acc_size = '0;
    logic [1:0]     acc_kind = '0;
    logic [1:0]     priv_lvl = '0;
    logic [NE*AW-1:0] rgn_base;
    logic [NE*AW-1:0] rgn_limit;
    logic [NE*8-1:0]  ent_cfg;
    logic           acc_ok;
    logic [3:0]     exc_code;

    logic [AW-1:0]  base_a [NE];
    logic [AW-1:0]  lim_a  [NE];
    logic [7:0]     cfg_a  [NE];

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NE; i++) begin
            rgn_base[i*AW +: AW] = base_a[i];
            rgn_limit[i*AW +: AW] = lim_a[i];
            ent_cfg[i*8 +: 8]    = cfg_a[i];
        end
    end

    mem_guard_check #(.ADDR_W(AW), .SIZE_W(SW), .N_ENT(NE), .REG_OUT(1'b1)) i_mem_guard_check (
        .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_kind(acc_kind), .priv_lvl(priv_lvl), .rgn_base(rgn_base),
        .rgn_limit(rgn_limit), .ent_cfg(ent_cfg), .acc_ok(acc_ok), .exc_code(exc_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d addr=%h size=%0d kind=%0d priv=%0d",
                     tag, act, exp, acc_addr, acc_size, acc_kind, priv_lvl);
        end
    endtask

    // Reference built from the requirements
    task automatic model(input int a, input int s, input int k, input int p,
                         output bit ok, output int code, output string tag);
        int  eff;
        int  last;
        bit  any_act;
        bit  any_lock;
        int  sel;
        int  nfull;
        bit  straddle;
        int  pbit;
        eff = (s == 0) ? 1 : s;
        last = a + eff - 1;
        any_act = 0; any_lock = 0; sel = -1; nfull = 0; straddle = 0;
        for (int i = 0; i < NE; i++) begin
            bit act_i;
            bit f_in;
            bit l_in;
            act_i = ((cfg_a[i] >> 3) & 3) != 0;
            if (act_i) any_act = 1;
            if (cfg_a[i][7]) any_lock = 1;
            f_in = (a >= base_a[i]) && (a < lim_a[i]);
            l_in = (last >= base_a[i]) && (last < lim_a[i]);
            if (act_i && f_in && l_in) begin
                nfull++;
                if (sel < 0) sel = i;
            end
            if (act_i && (f_in != l_in)) straddle = 1;
        end
        pbit = (k == 0) ? 0 : (k == 1) ? 1 : 2;
        if (!any_act || (p == 3 && !any_lock)) begin
            ok = 1; tag = "R6";
        end else if (sel >= 0) begin
            if (p == 3 && !cfg_a[sel][7]) begin
                ok = 1; tag = "R3";
            end else begin
                ok = cfg_a[sel][pbit]; tag = "R4";
            end
            if (nfull > 1) tag = "R1";
        end else begin
            ok = (p == 3); tag = "R5";
        end
        if (straddle) tag = "R2";
        if (s == 0) tag = "R8";
        code = ok ? 0 : (k == 0) ? 5 : (k == 1) ? 7 : 1;
    endtask

    task automatic run_vec(input int a, input int s, input int k, input int p);
        bit    ok;
        int    code;
        string tag;
        acc_addr = AW'(a);
        acc_size = SW'(s);
        acc_kind = 2'(k);
        priv_lvl = 2'(p);
        @(negedge clk);
        model(a, s, k, p, ok, code, tag);
        check(tag, int'(acc_ok), int'(ok));
        check("R7", int'(exc_code), code);
    endtask

    task automatic sweep(input int lo, input int hi, input int step);
        int sizes [5] = '{0, 1, 2, 4, 8};
        int privs [3] = '{0, 1, 3};
        for (int a = lo; a <= hi; a += step)
            for (int si = 0; si < 5; si++)
                for (int k = 0; k < 4; k++)
                    for (int pi = 0; pi < 3; pi++)
                        run_vec(a, sizes[si], k, privs[pi]);
    endtask

    task automatic set_ent(input int i, input int b, input int l, input int c);
        base_a[i] = AW'(b);
        lim_a[i]  = AW'(l);
        cfg_a[i]  = 8'(c);
    endtask

    initial begin
        for (int i = 0; i < NE; i++) set_ent(i, 0, 0, 0);
        // Reset state
        acc_addr = 16'h0010; acc_kind = 2'd1; priv_lvl = 2'd0; acc_size = 4'd1;
        set_ent(0, 16'h0100, 16'h0200, 8'h08);
        repeat (3) @(negedge clk);
        check("R9", int'(acc_ok), 1);
        check("R9", int'(exc_code), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R5", int'(acc_ok), 0);
        check("R7", int'(exc_code), 7);

        // One-cycle latency: new inputs not visible before the next edge
        acc_addr = 16'h0180; acc_kind = 2'd0;
        set_ent(0, 16'h0100, 16'h0200, 8'h09);
        #1;
        check("R9", int'(acc_ok), 0);
        @(negedge clk);
        check("R9", int'(acc_ok), 1);

        // Table A: overlap, inactive entry with perms, locked execute-only
        set_ent(0, 16'h0100, 16'h0140, 8'h09);
        set_ent(1, 16'h0120, 16'h0200, 8'h0F);
        set_ent(2, 16'h0300, 16'h0380, 8'h07);
        set_ent(3, 16'h03C0, 16'h0480, 8'h9C);
        sweep(16'h00E0, 16'h04A0, 3);

        // Table B: locked low entry overlapping an unlocked permissive one
        set_ent(0, 16'h0200, 16'h0240, 8'h89);
        set_ent(1, 16'h01F0, 16'h0300, 16'h0F);
        set_ent(2, 16'h0280, 16'h02C0, 8'h0A);
        set_ent(3, 16'h0000, 16'h0000, 8'h00);
        sweep(16'h01E0, 16'h0320, 3);

        // Table C: all unlocked, machine passes everywhere
        set_ent(0, 16'h0040, 16'h0080, 8'h11);
        set_ent(1, 16'h0080, 16'h00C0, 8'h12);
        set_ent(2, 16'h00A0, 16'h0100, 8'h1C);
        set_ent(3, 16'h0000, 16'h0000, 8'h00);
        sweep(16'h0030, 16'h0110, 5);

        // Table D: nothing active, one stray lock bit
        set_ent(0, 16'h0040, 16'h0080, 8'h87);
        set_ent(1, 16'h0080, 16'h00C0, 8'h02);
        set_ent(2, 16'h0000, 16'h0000, 8'h00);
        set_ent(3, 16'h0000, 16'h0000, 8'h00);
        sweep(16'h0030, 16'h00D0, 7);

        // Table E: lock bit on an inactive entry enables machine checking
        set_ent(0, 16'h0040, 16'h0080, 8'h80);
        set_ent(1, 16'h0080, 16'h00C0, 8'h09);
        sweep(16'h0030, 16'h00D0, 7);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule